// File: doc/BRIEF.md
# SMM Region Configuration Registers and Address Decoder

This block keeps the configuration for system-management memory: a 32-bit header base address, a 20-bit region base (address bits 31:12) and a 4-bit size code. Software reaches these values through a pair of byte ports. A write to the index port selects a register byte. Later reads or writes on the data port then go to that byte. The index stays selected until the index port is written again.

Two mode inputs protect the values. The header bytes can be seen and changed only while the map-enable input is high. The region base and size can be written only while the lock input is low or the SMI-active input is high.

The block also decodes a physical address on a compare port. The hit output goes high, in the same cycle, when the address falls inside the region that the base and size code describe. Size code 0 turns decoding off. Codes 1 to 14 select sizes from 4 KB to 32 MB, doubling at each step. Code 15 selects 4 KB, the same as code 1.

Top module: `smm_region_regs`

## Requirements
- R1: Index values select bytes as follows. 0xB0, 0xB1, 0xB2 and 0xB3 are header bits 7:0, 15:8, 23:16 and 31:24. 0xCD is region base bits 31:24 and 0xCE is base bits 23:16. 0xCF is {base bits 15:12, size code} with the size code in bits 3:0. A data write stores its byte into the selected field, and a data read returns that field on `dat_out`. The index is written with `idx_wr`, is kept until the next index write, and applies to every data access made after it.
- R2: After a write to an index the block does not own, a read gives `dat_oe`=0 and `dat_out`=0. A write to such an index changes no register.
- R3: While `map_en`=0, reads of the header indices give `dat_oe`=0 and writes to them are ignored. While `map_en`=1, header reads and writes work normally.
- R4: A write to 0xCD, 0xCE or 0xCF takes effect only when `lock`=0 or `smi_active`=1. In every other case the stored value is left as it was.
- R5: A single write to 0xCF updates base bits 15:12 and the size code together, and a read of 0xCF returns both.
- R6: After reset the header, the region base, the size code and the index all read as zero, and `hit` is 0.
- R7: While the size code is 0, `hit` is 0 for every address.
- R8: For size code s from 1 to 14 the region size is 4 KB × 2^(s-1). Code 15 gives 4 KB. `hit` is 1 exactly when address bits 31:log2(size) equal the same bits of the base.
- R9: Base bits below the region size have no effect on `hit`.
- R10: `hit` follows `cmp_addr` combinationally. A register write changes `hit` starting with the cycle after the write edge.
- R11: A read drives `dat_out` and `dat_oe` in the same cycle as `dat_rd`. While no read is driven, `dat_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Write strobe for the index port |
| idx_in | input | 8 | Index value |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe |
| dat_in | input | 8 | Data write byte |
| dat_out | output | 8 | Data read byte |
| dat_oe | output | 1 | High while `dat_out` is driven |
| map_en | input | 1 | Opens access to the header bytes |
| lock | input | 1 | Protects the region registers against writes |
| smi_active | input | 1 | SMI mode, which overrides the lock |
| cmp_addr | input | 32 | Physical address to decode |
| hit | output | 1 | High when `cmp_addr` is inside the region |

## Verification
The decoder is tried with every size code on a base whose low bits are all ones. The probes are the first and last byte of the aligned region and the bytes just below and just above it. This separates an off-by-one size from a correct one, and shows that code 15 acts like code 1 and that code 0 never hits. Register access is run with each combination of lock and SMI-active, and with map enable both high and low. Each blocked write is followed by a read-back, which separates a write that was ignored from one that was stored. Writes to unowned indices and reads of them show that the bus is left undriven and that no field is changed.

// File: rtl/smm_region_regs.sv
module smm_region_regs #(
  parameter logic [7:0] HDR_IDX0 = 8'hB0,
  parameter logic [7:0] RGN_IDX0 = 8'hCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic [7:0]  idx_in,
  input  logic        dat_wr,
  input  logic        dat_rd,
  input  logic [7:0]  dat_in,
  output logic [7:0]  dat_out,
  output logic        dat_oe,
  input  logic        map_en,
  input  logic        lock,
  input  logic        smi_active,
  input  logic [31:0] cmp_addr,
  output logic        hit
);
  localparam logic [7:0] RGN_IDX1 = RGN_IDX0 + 8'd1;
  localparam logic [7:0] RGN_IDX2 = RGN_IDX0 + 8'd2;

  logic [7:0]  idx_q;
  logic [31:0] hdr_q;
  logic [19:0] base_q;
  logic [3:0]  size_q;

  logic       hdr_sel, rgn_sel, hdr_ok, rgn_wr_ok;
  logic [1:0] hdr_byte;

  assign hdr_sel   = (idx_q[7:2] == HDR_IDX0[7:2]);
  assign hdr_byte  = idx_q[1:0];
  assign rgn_sel   = (idx_q == RGN_IDX0) || (idx_q == RGN_IDX1) || (idx_q == RGN_IDX2);
  assign hdr_ok    = hdr_sel && map_en;
  assign rgn_wr_ok = !lock || smi_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      hdr_q  <= '0;
      base_q <= '0;
      size_q <= '0;
    end else begin
      if (idx_wr) idx_q <= idx_in;
      if (dat_wr && hdr_ok) hdr_q[hdr_byte*8 +: 8] <= dat_in;
      if (dat_wr && rgn_sel && rgn_wr_ok) begin
        if (idx_q == RGN_IDX0) base_q[19:12] <= dat_in;
        if (idx_q == RGN_IDX1) base_q[11:4]  <= dat_in;
        if (idx_q == RGN_IDX2) {base_q[3:0], size_q} <= dat_in;
      end
    end
  end

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    if (hdr_ok) rd_byte = hdr_q[hdr_byte*8 +: 8];
    else if (idx_q == RGN_IDX0) rd_byte = base_q[19:12];
    else if (idx_q == RGN_IDX1) rd_byte = base_q[11:4];
    else if (idx_q == RGN_IDX2) rd_byte = {base_q[3:0], size_q};
  end

  assign dat_oe  = dat_rd && (hdr_ok || rgn_sel);
  assign dat_out = dat_oe ? rd_byte : 8'h00;

  logic [4:0]  shamt;
  logic [19:0] cmp_mask;
  assign shamt    = (size_q == 4'hF || size_q == 4'h0) ? 5'd0 : {1'b0, size_q} - 5'd1;
  assign cmp_mask = ~((20'h1 << shamt) - 20'h1);
  assign hit      = (size_q != 4'h0) && (((cmp_addr[31:12] ^ base_q) & cmp_mask) == 20'h0);

  // R3
  hdr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !map_en) |=> $stable(hdr_q));
  // R4
  rgn_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && lock && !smi_active) |=> ($stable(base_q) && $stable(size_q)));
  // R7
  size_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == 4'h0) |-> !hit);
  // R2
  unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_sel && !rgn_sel) |-> !dat_oe);
  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_rd |-> (dat_out == 8'h00 && !dat_oe));
endmodule

// File: tb/tb_smm_region_regs.sv
`timescale 1ns/1ps
module tb_smm_region_regs;
  logic clk = 0, rst_n = 0;
  logic idx_wr = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0] idx_in = 0, dat_in = 0;
  logic map_en = 0, lock = 0, smi_active = 0;
  logic [31:0] cmp_addr = 0;
  logic [7:0] dat_out;
  logic dat_oe, hit;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  smm_region_regs dut (.clk, .rst_n, .idx_wr, .idx_in, .dat_wr, .dat_rd, .dat_in,
    .dat_out, .dat_oe, .map_en, .lock, .smi_active, .cmp_addr, .hit);

  // behavioural reference model
  int m_idx, m_hdr[4], m_base, m_size;

  function automatic bit m_hdr_idx(int i); return i >= 'hB0 && i <= 'hB3; endfunction
  function automatic bit m_rgn_idx(int i); return i == 'hCD || i == 'hCE || i == 'hCF; endfunction

  function automatic longint region_bytes(int s);
    if (s == 15) return 4096;
    return longint'(4096) << (s - 1);
  endfunction

  function automatic bit m_hit(logic [31:0] a);
    longint sz, lo, top;
    if (m_size == 0) return 0;
    sz  = region_bytes(m_size);
    top = longint'(m_base) * 4096;
    lo  = (top / sz) * sz;
    return (longint'(a) >= lo) && (longint'(a) < lo + sz);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_base = 0; m_size = 0;
      foreach (m_hdr[i]) m_hdr[i] = 0;
    end else begin
      if (dat_wr) begin
        if (m_hdr_idx(m_idx) && map_en) m_hdr[m_idx - 'hB0] = dat_in;
        if (m_rgn_idx(m_idx) && (!lock || smi_active)) begin
          case (m_idx)
            'hCD: m_base = (m_base % 4096) + dat_in * 4096;
            'hCE: m_base = (m_base / 4096) * 4096 + dat_in * 16 + (m_base % 16);
            default: begin m_base = (m_base / 16) * 16 + dat_in / 16; m_size = dat_in % 16; end
          endcase
        end
      end
      if (idx_wr) m_idx = idx_in;
    end
  end

  function automatic int m_read(output bit oe);
    oe = 0;
    if (!dat_rd) return 0;
    if (m_hdr_idx(m_idx) && map_en) begin oe = 1; return m_hdr[m_idx - 'hB0]; end
    if (m_idx == 'hCD) begin oe = 1; return m_base / 4096; end
    if (m_idx == 'hCE) begin oe = 1; return (m_base / 16) % 256; end
    if (m_idx == 'hCF) begin oe = 1; return (m_base % 16) * 16 + m_size; end
    return 0;
  endfunction

  always @(negedge clk) begin
    bit eo; int ed;
    if (rst_n && !finished) begin
      ed = m_read(eo);
      n_chk++;
      if (dat_oe !== eo || dat_out !== 8'(ed)) begin
        n_fail++;
        $display("FAIL R1/R11 model: oe=%0b out=%02h expected oe=%0b out=%02h", dat_oe, dat_out, eo, ed);
      end
      n_chk++;
      if (hit !== m_hit(cmp_addr)) begin
        n_fail++;
        $display("FAIL R8 model: hit=%0b expected %0b at %08h", hit, m_hit(cmp_addr), cmp_addr);
      end
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr_idx(input logic [7:0] v); idx_wr = 1; idx_in = v; cyc(); idx_wr = 0; endtask
  task automatic wr_dat(input logic [7:0] v); dat_wr = 1; dat_in = v; cyc(); dat_wr = 0; endtask
  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v); wr_idx(i); wr_dat(v); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] i, input logic oe, input logic [7:0] v);
    wr_idx(i);
    dat_rd = 1; #0.5;
    chk(req, {23'd0, dat_oe, dat_out}, {23'd0, oe, (oe ? v : 8'h00)});
    cyc(); dat_rd = 0;
  endtask

  task automatic hit_chk(input string req, input logic [31:0] a, input logic e);
    cmp_addr = a; #0.5;
    chk(req, {31'd0, hit}, {31'd0, e});
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    // R6 reset values
    map_en = 1;
    rd_chk("R6", 8'hB3, 1, 8'h00);
    rd_chk("R6", 8'hCF, 1, 8'h00);
    hit_chk("R6", 32'h0000_0000, 0);
    // R11 idle bus
    chk("R11", {23'd0, dat_oe, dat_out}, 0);

    // R1 header bytes and region bytes
    wr_reg(8'hB0, 8'h11); wr_reg(8'hB1, 8'h22); wr_reg(8'hB2, 8'h33); wr_reg(8'hB3, 8'h44);
    rd_chk("R1", 8'hB3, 1, 8'h44);
    rd_chk("R1", 8'hB0, 1, 8'h11);
    // R3 map_en gating
    map_en = 0;
    rd_chk("R3", 8'hB2, 0, 8'h00);
    wr_reg(8'hB2, 8'hEE);
    map_en = 1;
    rd_chk("R3", 8'hB2, 1, 8'h33);

    // R2 unowned index
    wr_reg(8'hC0, 8'h5A);
    rd_chk("R2", 8'hC0, 0, 8'h00);
    rd_chk("R2", 8'hB1, 1, 8'h22);
    rd_chk("R2", 8'hCD, 1, 8'h00);

    // R4 lock handling
    lock = 1; smi_active = 0;
    wr_reg(8'hCD, 8'h55);
    rd_chk("R4", 8'hCD, 1, 8'h00);
    smi_active = 1;
    wr_reg(8'hCD, 8'h00);
    wr_reg(8'hCE, 8'hA0);
    rd_chk("R4", 8'hCE, 1, 8'hA0);
    smi_active = 0; lock = 0;

    // R5 shared index, R10 takes effect after write edge
    wr_idx(8'hCF);
    cmp_addr = 32'h00A0_F000;
    dat_wr = 1; dat_in = 8'hF5; #0.5;
    chk("R10", {31'd0, hit}, 0);
    cyc(); dat_wr = 0; #0.5;
    chk("R10", {31'd0, hit}, 1);
    rd_chk("R5", 8'hCF, 1, 8'hF5);

    // R9 low base bits ignored for 64 KB
    hit_chk("R9", 32'h00A0_0000, 1);
    hit_chk("R9", 32'h00A1_0000, 0);

    // R7, R8 every size code on base 0x00A0F000
    for (int s = 0; s < 16; s++) begin
      longint sz, lo;
      wr_reg(8'hCF, {4'hF, 4'(s)});
      if (s == 0) begin
        hit_chk("R7", 32'h00A0_F000, 0);
        hit_chk("R7", 32'h0000_0000, 0);
      end else begin
        sz = region_bytes(s);
        lo = (longint'(32'h00A0_F000) / sz) * sz;
        hit_chk("R8", 32'(lo), 1);
        hit_chk("R8", 32'(lo + sz - 1), 1);
        hit_chk("R8", 32'(lo + sz), 0);
        hit_chk("R8", 32'(lo - 1), 0);
      end
    end
    // R8 code 15 alias to 4 KB
    wr_reg(8'hCF, 8'hFF);
    hit_chk("R8", 32'h00A0_FFFF, 1);
    hit_chk("R8", 32'h00A1_0000, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule